// File: doc/BRIEF.md
# DMA Channel Completion Result and Interrupt Hub

This block sits between a bank of DMA channel engines and the software that drives them. When a channel engine finishes a command list, it reports a one-cycle result naming how the list ended: it finished normally, it stopped on an error, or it was flushed. The hub queues that result per channel and exposes it through a word-addressed register bus. It raises a single interrupt line while any enabled channel holds an unread result. Software reads a channel's result word to learn the outcome, and that read also acknowledges it.

Software ends a channel's running list by writing that channel's flush register. The hub turns the write into a one-cycle flush request toward the engine, tagged as graceful or immediate. The engine later reports the ended transaction as a flushed result. Each channel has its own configuration word. It enables the completion interrupt and separately decides whether flushed results may raise it. A summary word gathers the pending interrupt bits of all channels.

Top module: `dma_result_irq_hub`

## Requirements
- R1: After synchronous active-low reset, every channel queue is empty, every configuration and sticky bit is 0, `irq` is 0 and `flush_req` is 0; every register reads 0.
- R2: The result word of channel i is at byte address 0x040 + 4*i. When its queue is non-empty it reads bit 31 = 1, bit 3 = error, bit 2 = flushed, and bit 1 = 1 only when neither error nor flushed is set, with all other bits 0. When the queue is empty it reads 0.
- R3: A bus read of a result word removes the oldest queued result of that channel in the same clock edge, and the next queued result becomes visible. Once the queue is empty, the channel's present bit and interrupt bit are 0.
- R4: The status word of channel i is at 0x200 + 4*i. Bit 1 is 1 while a result is queued. Bit 3 is a sticky lost-result flag that stays set until a write to that status word with bit 3 = 1. All other status bits read 0.
- R5: Each channel queues up to 2 results in arrival order. A result that arrives while 2 are queued and none is being read in that cycle is dropped and sets the lost flag. A result that arrives in the same cycle as a read of a full queue is kept.
- R6: Writing the flush word of channel i at 0x080 + 4*i drives `flush_req[i]` high for exactly the one cycle after the write. In that cycle `flush_graceful[i]` equals bit 31 of the written data (1 = graceful, 0 = immediate). The flush word reads 0.
- R7: The configuration word of channel i is at 0x300 + 4*i. Bit 0 enables the channel interrupt and bit 1 lets flushed results raise it. Both bits are read/write; other bits read 0.
- R8: The interrupt summary word at 0x380 has bit i set when channel i holds a result, its interrupt enable is 1, and either the oldest result is not flushed or flush reporting is enabled. `irq` is 1 when any summary bit is 1.
- R9: Writes to result words and to the summary word have no effect. Reads of unmapped addresses, of channel slots at or above NUM_CH, or of addresses with non-zero low two bits return 0.
- R10: Results from different channels arriving in the same cycle are each captured by their own channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read strobe |
| res_valid | input | NUM_CH (16) | Per-channel one-cycle result report |
| res_err | input | NUM_CH (16) | Error flag of the report, per channel |
| res_flushed | input | NUM_CH (16) | Flushed flag of the report, per channel |
| flush_req | output | NUM_CH (16) | One-cycle flush request toward each engine |
| flush_graceful | output | NUM_CH (16) | Flush kind qualifying flush_req: 1 graceful, 0 immediate |
| irq | output | 1 | Combined interrupt line |

## Verification
Several properties are checked on every cycle: the interrupt line is quiet on the first cycle after reset, it never rises without an enabled channel holding a result, a flush request follows a bus write, and a lost-result flag never clears except after a bus write. The bench scenarios are needed for the rest. These are the result-word bit encoding, the in-order popping of two queued results, the drop-newest rule against a kept result on a simultaneous read, the flush-reporting gate, and the ignored writes. All of them depend on values that only a directed stimulus sequence produces.

// File: rtl/dma_rpt_pkg.sv
// Package: shared types and the fixed register layout of the result hub.
// Assumes 4-byte channel spacing inside 64-byte banks, so at most 16 channels.
package dma_rpt_pkg;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RSLT,
        SEL_FLUSH,
        SEL_STAT,
        SEL_CONF,
        SEL_IRQW
    } sel_e;

    typedef struct packed {
        logic err;
        logic flushed;
    } rslt_t;

    // Bank numbers are byte offset / 64
    localparam int BANK_RSLT  = 1;    // 0x040
    localparam int BANK_FLUSH = 2;    // 0x080
    localparam int BANK_STAT  = 8;    // 0x200
    localparam int BANK_CONF  = 12;   // 0x300
    localparam int IRQW_ADDR  = 'h380;

    // Bit positions
    localparam int RB_VALID   = 31;
    localparam int RB_ERR     = 3;
    localparam int RB_FLUSHED = 2;
    localparam int RB_DONE    = 1;
    localparam int SB_PRESENT = 1;
    localparam int SB_LOST    = 3;
    localparam int CB_IRQ_EN  = 0;
    localparam int CB_FL_EN   = 1;
    localparam int FB_GRACE   = 31;

endpackage

// File: rtl/dma_rpt_decode.sv
// Module: address decoder. Turns a byte address into a register kind and a
// channel slot. Assumes ADDR_W >= 12 and NUM_CH <= 16; anything unmapped
// decodes to SEL_NONE.
module dma_rpt_decode
    import dma_rpt_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NUM_CH = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel,
    output logic [3:0]        idx
);
    localparam int BANK_W = ADDR_W - 6;

    logic [BANK_W-1:0] bank;
    logic              aligned;
    logic              slot_ok;

    assign bank    = addr[ADDR_W-1:6];
    assign idx     = addr[5:2];
    assign aligned = (addr[1:0] == 2'b00);
    assign slot_ok = ({28'd0, idx} < 32'(NUM_CH));

    // Purpose: classify the access by bank, alignment and slot range
    always_comb begin
        sel = SEL_NONE;
        if (addr == ADDR_W'(IRQW_ADDR))
            sel = SEL_IRQW;
        else if (aligned && slot_ok) begin
            if (bank == BANK_W'(BANK_RSLT))       sel = SEL_RSLT;
            else if (bank == BANK_W'(BANK_FLUSH)) sel = SEL_FLUSH;
            else if (bank == BANK_W'(BANK_STAT))  sel = SEL_STAT;
            else if (bank == BANK_W'(BANK_CONF))  sel = SEL_CONF;
        end
    end
endmodule

// File: rtl/dma_rpt_queue.sv
// Module: small in-order result queue for one channel. Assumes DEPTH >= 2.
// A push into a full queue is dropped and flagged unless a pop happens in
// the same cycle.
module dma_rpt_queue
    import dma_rpt_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push,
    input  rslt_t push_data,
    input  logic  pop,
    output rslt_t head,
    output logic  present,
    output logic  overflow
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    rslt_t            mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;
    logic             full, push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign present  = (count != '0);
    assign full     = (count == CNT_W'(DEPTH));
    assign pop_ok   = pop && present;
    assign push_ok  = push && (!full || pop_ok);
    assign overflow = push && !push_ok;
    assign head     = mem[rd_ptr];

    // Purpose: store pushed entries and advance pointers and fill count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
        end else begin
            if (push_ok) begin
                mem[wr_ptr] <= push_data;
                wr_ptr      <= nxt(wr_ptr);
            end
            if (pop_ok) rd_ptr <= nxt(rd_ptr);
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/dma_rpt_chan.sv
// Module: one channel slice. Holds the result queue, the configuration bits,
// the sticky lost flag and the flush request register, and forms the
// channel's read words and interrupt bit. Assumes hit is already qualified
// with the bus strobe and this channel's slot.
module dma_rpt_chan
    import dma_rpt_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hit,
    input  logic        we,
    input  sel_e        sel,
    input  logic        wd_grace,
    input  logic        wd_lost_clr,
    input  logic [1:0]  wd_conf,
    input  logic        res_valid,
    input  logic        res_err,
    input  logic        res_flushed,
    output logic [31:0] rslt_word,
    output logic [31:0] stat_word,
    output logic [31:0] conf_word,
    output logic        irq_pend,
    output logic        present,
    output logic        irq_en,
    output logic        lost,
    output logic        flush_req,
    output logic        flush_graceful
);
    rslt_t head;
    logic  overflow, flush_en;
    logic  pop, wr_flush, wr_conf, wr_stat;

    assign pop      = hit && !we && (sel == SEL_RSLT);
    assign wr_flush = hit &&  we && (sel == SEL_FLUSH);
    assign wr_conf  = hit &&  we && (sel == SEL_CONF);
    assign wr_stat  = hit &&  we && (sel == SEL_STAT);

    dma_rpt_queue #(.DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (res_valid),
        .push_data ('{err: res_err, flushed: res_flushed}),
        .pop       (pop),
        .head      (head),
        .present   (present),
        .overflow  (overflow)
    );

    // Purpose: configuration bits written by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en   <= 1'b0;
            flush_en <= 1'b0;
        end else if (wr_conf) begin
            irq_en   <= wd_conf[CB_IRQ_EN];
            flush_en <= wd_conf[CB_FL_EN];
        end
    end

    // Purpose: sticky lost flag, set by overflow, cleared by write-one
    always_ff @(posedge clk) begin
        if (!rst_n)                      lost <= 1'b0;
        else if (overflow)               lost <= 1'b1;
        else if (wr_stat && wd_lost_clr) lost <= 1'b0;
    end

    // Purpose: one-cycle flush request with its kind
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_req      <= 1'b0;
            flush_graceful <= 1'b0;
        end else begin
            flush_req      <= wr_flush;
            flush_graceful <= wr_flush && wd_grace;
        end
    end

    // Purpose: assemble the readable words of this channel
    always_comb begin
        rslt_word = '0;
        if (present) begin
            rslt_word[RB_VALID]   = 1'b1;
            rslt_word[RB_ERR]     = head.err;
            rslt_word[RB_FLUSHED] = head.flushed;
            rslt_word[RB_DONE]    = !head.err && !head.flushed;
        end
        stat_word             = '0;
        stat_word[SB_PRESENT] = present;
        stat_word[SB_LOST]    = lost;
        conf_word             = '0;
        conf_word[CB_IRQ_EN]  = irq_en;
        conf_word[CB_FL_EN]   = flush_en;
    end

    assign irq_pend = present && irq_en && (!head.flushed || flush_en);
endmodule

// File: rtl/dma_result_irq_hub.sv
// Module: top of the result hub. Decodes register accesses, instantiates one
// slice per channel, muxes read data and combines the interrupt bits.
// Assumes one access per cycle with read data consumed in the same cycle.
module dma_result_irq_hub
    import dma_rpt_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_CH-1:0] res_valid,
    input  logic [NUM_CH-1:0] res_err,
    input  logic [NUM_CH-1:0] res_flushed,
    output logic [NUM_CH-1:0] flush_req,
    output logic [NUM_CH-1:0] flush_graceful,
    output logic              irq
);
    sel_e              sel;
    logic [3:0]        idx;
    logic [31:0]       rslt_w [NUM_CH];
    logic [31:0]       stat_w [NUM_CH];
    logic [31:0]       conf_w [NUM_CH];
    logic [NUM_CH-1:0] irq_vec;
    logic [NUM_CH-1:0] ch_present;
    logic [NUM_CH-1:0] ch_irq_en;
    logic [NUM_CH-1:0] ch_lost;

    dma_rpt_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_decode (
        .addr (bus_addr),
        .sel  (sel),
        .idx  (idx)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        dma_rpt_chan #(.DEPTH(DEPTH)) u_chan (
            .clk            (clk),
            .rst_n          (rst_n),
            .hit            (bus_req && (idx == 4'(i))),
            .we             (bus_we),
            .sel            (sel),
            .wd_grace       (bus_wdata[FB_GRACE]),
            .wd_lost_clr    (bus_wdata[SB_LOST]),
            .wd_conf        (bus_wdata[1:0]),
            .res_valid      (res_valid[i]),
            .res_err        (res_err[i]),
            .res_flushed    (res_flushed[i]),
            .rslt_word      (rslt_w[i]),
            .stat_word      (stat_w[i]),
            .conf_word      (conf_w[i]),
            .irq_pend       (irq_vec[i]),
            .present        (ch_present[i]),
            .irq_en         (ch_irq_en[i]),
            .lost           (ch_lost[i]),
            .flush_req      (flush_req[i]),
            .flush_graceful (flush_graceful[i])
        );
    end

    // Purpose: select read data by register kind and channel slot
    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_RSLT: bus_rdata = rslt_w[idx];
            SEL_STAT: bus_rdata = stat_w[idx];
            SEL_CONF: bus_rdata = conf_w[idx];
            SEL_IRQW: bus_rdata = 32'(irq_vec);
            default:  bus_rdata = '0;
        endcase
    end

    assign irq = |irq_vec;
endmodule

// File: rtl/dma_result_irq_hub_chk.sv
// Module: property checker for the result hub, attached by bind below.
module dma_result_irq_hub_chk #(
    parameter int NUM_CH = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic              irq,
    input logic [NUM_CH-1:0] flush_req,
    input logic [NUM_CH-1:0] present,
    input logic [NUM_CH-1:0] irq_en,
    input logic [NUM_CH-1:0] lost
);
    // R1: interrupt quiet on the first cycle out of reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !irq);

    // R8: interrupt needs an enabled channel
    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en != '0));

    // R3: interrupt needs a queued result
    a_r3_irq_needs_result: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (present != '0));

    // R6: flush request only after a bus write
    a_r6_flush_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req != '0) |-> $past(bus_req && bus_we));

    // R4: lost flag clears only after a bus write
    a_r4_lost_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(lost) & ~lost) != '0) |-> $past(bus_req && bus_we));
endmodule

bind dma_result_irq_hub dma_result_irq_hub_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .irq       (irq),
    .flush_req (flush_req),
    .present   (ch_present),
    .irq_en    (ch_irq_en),
    .lost      (ch_lost)
);

// File: tb/dma_result_irq_hub_bench.sv
// Directed bench: each task drives one scenario and checks its own results.
module dma_result_irq_hub_bench;
    localparam int NUM_CH = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_req = 1'b0;
    logic              bus_we = 1'b0;
    logic [11:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NUM_CH-1:0] res_valid = '0;
    logic [NUM_CH-1:0] res_err = '0;
    logic [NUM_CH-1:0] res_flushed = '0;
    logic [NUM_CH-1:0] flush_req;
    logic [NUM_CH-1:0] flush_graceful;
    logic              irq;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    dma_result_irq_hub u_dma_result_irq_hub (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_req        (bus_req),
        .bus_we         (bus_we),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .res_valid      (res_valid),
        .res_err        (res_err),
        .res_flushed    (res_flushed),
        .flush_req      (flush_req),
        .flush_graceful (flush_graceful),
        .irq            (irq)
    );

    function automatic logic [11:0] a_rslt(input int c);  return 12'(32'h040 + 4 * c); endfunction
    function automatic logic [11:0] a_flush(input int c); return 12'(32'h080 + 4 * c); endfunction
    function automatic logic [11:0] a_stat(input int c);  return 12'(32'h200 + 4 * c); endfunction
    function automatic logic [11:0] a_conf(input int c);  return 12'(32'h300 + 4 * c); endfunction
    localparam logic [11:0] A_IRQW = 12'h380;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic post(input logic [NUM_CH-1:0] m, input logic e, input logic f);
        @(negedge clk);
        res_valid = m;
        res_err = e ? m : '0;
        res_flushed = f ? m : '0;
        @(negedge clk);
        res_valid = '0; res_err = '0; res_flushed = '0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 irq", 32'(irq), 0);
        chk("R1 flush_req", 32'(flush_req), 0);
        bus_read(a_rslt(0), d);  chk("R1 result ch0", d, 0);
        bus_read(a_stat(15), d); chk("R1 status ch15", d, 0);
        bus_read(a_conf(3), d);  chk("R1 conf ch3", d, 0);
        bus_read(A_IRQW, d);     chk("R1 irq word", d, 0);
    endtask

    task automatic t_normal;
        logic [31:0] d;
        bus_write(a_conf(3), 32'h1);
        post(16'h0008, 1'b0, 1'b0);
        bus_read(a_stat(3), d); chk("R4 status present", d, 32'h2);
        bus_read(A_IRQW, d);    chk("R8 irq word ch3", d, 32'h8);
        chk("R8 irq line", 32'(irq), 1);
        bus_read(a_rslt(3), d); chk("R2 done result", d, 32'h8000_0002);
        chk("R3 irq cleared", 32'(irq), 0);
        bus_read(a_stat(3), d); chk("R3 status cleared", d, 0);
        bus_read(a_rslt(3), d); chk("R2 empty reads zero", d, 0);
    endtask

    task automatic t_error;
        logic [31:0] d;
        post(16'h0020, 1'b1, 1'b0);
        chk("R8 masked irq", 32'(irq), 0);
        bus_read(A_IRQW, d);    chk("R8 masked word", d, 0);
        bus_read(a_rslt(5), d); chk("R2 error result", d, 32'h8000_0008);
    endtask

    task automatic t_flush_gate;
        logic [31:0] d;
        bus_write(a_conf(7), 32'h1);
        post(16'h0080, 1'b0, 1'b1);
        chk("R8 flush not reported", 32'(irq), 0);
        bus_read(a_stat(7), d); chk("R4 flushed present", d, 32'h2);
        bus_write(a_conf(7), 32'h3);
        chk("R8 flush reported", 32'(irq), 1);
        bus_read(A_IRQW, d);    chk("R8 word ch7", d, 32'h80);
        bus_read(a_rslt(7), d); chk("R2 flushed result", d, 32'h8000_0004);
        chk("R3 irq after pop", 32'(irq), 0);
    endtask

    task automatic t_queue;
        logic [31:0] d;
        post(16'h0004, 1'b0, 1'b0);
        post(16'h0004, 1'b1, 1'b0);
        post(16'h0004, 1'b0, 1'b1);
        bus_read(a_stat(2), d); chk("R5 lost set", d, 32'hA);
        bus_read(a_rslt(2), d); chk("R5 first in order", d, 32'h8000_0002);
        bus_read(a_rslt(2), d); chk("R5 second in order", d, 32'h8000_0008);
        bus_read(a_rslt(2), d); chk("R5 third dropped", d, 0);
        bus_read(a_stat(2), d); chk("R4 lost stays", d, 32'h8);
        bus_write(a_stat(2), 32'h8);
        bus_read(a_stat(2), d); chk("R4 lost cleared", d, 0);
        post(16'h0004, 1'b0, 1'b0);
        post(16'h0004, 1'b1, 1'b0);
        fork
            bus_read(a_rslt(2), d);
            post(16'h0004, 1'b0, 1'b1);
        join
        chk("R3 pop returns oldest", d, 32'h8000_0002);
        bus_read(a_rslt(2), d); chk("R5 next after pop", d, 32'h8000_0008);
        bus_read(a_rslt(2), d); chk("R5 kept on read", d, 32'h8000_0004);
        bus_read(a_stat(2), d); chk("R5 no loss on read", d, 0);
    endtask

    task automatic t_flush_cmd;
        logic [31:0] d;
        bus_write(a_flush(9), 32'h8000_0000);
        chk("R6 req ch9", 32'(flush_req), 32'h200);
        chk("R6 graceful ch9", 32'(flush_graceful), 32'h200);
        @(negedge clk);
        chk("R6 single cycle", 32'(flush_req), 0);
        bus_write(a_flush(0), 32'h0);
        chk("R6 req ch0", 32'(flush_req), 32'h1);
        chk("R6 immediate ch0", 32'(flush_graceful), 0);
        bus_read(a_flush(9), d); chk("R6 flush reads zero", d, 0);
    endtask

    task automatic t_conf;
        logic [31:0] d;
        bus_write(a_conf(4), 32'hFFFF_FFFF);
        bus_read(a_conf(4), d); chk("R7 conf bits", d, 32'h3);
        bus_write(a_conf(4), 32'h2);
        bus_read(a_conf(4), d); chk("R7 conf rewrite", d, 32'h2);
    endtask

    task automatic t_ignored;
        logic [31:0] d;
        bus_write(a_rslt(1), 32'hFFFF_FFFF);
        bus_read(a_rslt(1), d); chk("R9 result write ignored", d, 0);
        bus_write(A_IRQW, 32'hFFFF_FFFF);
        bus_read(A_IRQW, d);    chk("R9 irq word write ignored", d, 0);
        chk("R9 irq still low", 32'(irq), 0);
        bus_read(12'h3FC, d);   chk("R9 unmapped", d, 0);
        bus_write(a_conf(6), 32'h3);
        bus_read(12'h302 + 12'h18, d); chk("R9 misaligned", d, 0);
    endtask

    task automatic t_multi;
        logic [31:0] d;
        bus_write(a_conf(0), 32'h1);
        bus_write(a_conf(15), 32'h1);
        post(16'h8001, 1'b0, 1'b0);
        bus_read(A_IRQW, d);     chk("R10 both pending", d, 32'h8001);
        bus_read(a_rslt(15), d); chk("R10 ch15 result", d, 32'h8000_0002);
        bus_read(A_IRQW, d);     chk("R10 ch0 remains", d, 32'h1);
        bus_read(a_rslt(0), d);  chk("R10 ch0 result", d, 32'h8000_0002);
        chk("R10 irq low", 32'(irq), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_error();
        t_flush_gate();
        t_queue();
        t_flush_cmd();
        t_conf();
        t_ignored();
        t_multi();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule